// File: doc/BRIEF.md
# Sparsified Pixel Counter Readout Chain

This block is the digital back end of a photon-counting pixel array. Every pixel owns a 12-bit counter that climbs by one for each discharge pulse its charge-balancing converter emits. Since the pulse count per photon grows with the collected charge, the final value encodes photon energy. Converter pulses are not tied to any clock, so each pixel brings them into the clock domain through two flip-flops and an edge detector before counting.

When the array switches to readout, the counter registers themselves become stages of a single serial chain. Each pixel notes at that moment whether its count is zero. A zero pixel is routed around, so only pixels with data spend cycles on the serial line. Each pixel that holds data sends one 19-bit word: first its 7-bit position in the array, then its 12-bit count, most significant bit first in both fields. Words leave in rising pixel order with no gap between them, and a completion flag follows the last word.

Control is a mode input (count or read) and a synchronous clear, which a frame issues before counting starts. The overflow flag of each pixel is visible at all times.

Top module: `pixel_readout_chain`

## Requirements
- R1: After reset, valid_o, sof_o, done_o and every ovf_o bit are 0, and all counters hold zero.
- R2: In count mode (readout_i low), each rising edge on a pixel's pulse_i line raises that pixel's count by exactly one. The pulse line may change at any time and must stay high and low for at least two clock periods each.
- R3: A pixel whose count is 4095 keeps 4095 on further pulses, and it sets its ovf_o bit. The bit stays set until a clear.
- R4: clear_i, sampled high in count mode, sets every count to zero and drops every ovf_o bit at the next clock edge.
- R5: Pulse edges that arrive while readout_i is high change no count.
- R6: In readout, each word is 19 bits long, carried one bit per cycle on sdo_o while valid_o is high. Bits 18..12 are the pixel index and bits 11..0 are the count, both sent MSB first. sof_o is high exactly on bit 18 of each word.
- R7: Pixels whose count was zero when readout began send no word. The other pixels send their words in ascending index order, back to back with no idle cycle.
- R8: The first bit appears in the cycle after readout_i is seen high. done_o rises in the cycle after the last bit and stays high while readout_i is high. If every pixel is empty, done_o rises in the cycle after readout_i is seen high and no word is sent.
- R9: Lowering readout_i returns the block to count mode in the next cycle, with done_o and valid_o low. Counts are undefined until the next clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and readout clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| readout_i | input | 1 | Mode select: 0 count, 1 read out |
| clear_i | input | 1 | Synchronous frame clear (count mode only) |
| pulse_i | input | NPIX | Asynchronous discharge pulse line per pixel |
| sdo_o | output | 1 | Serial data, valid while valid_o is high |
| valid_o | output | 1 | A data bit is on sdo_o this cycle |
| sof_o | output | 1 | Current bit is the first (index MSB) of a word |
| done_o | output | 1 | All non-empty pixels have been sent |
| ovf_o | output | NPIX | Per-pixel saturation flag |

## Verification
The assertions check on every cycle that a counter never steps by more than one, that a saturated counter stays at its limit, and that an overflow flag stays set until a clear. They also check that cells are frozen while neither counting, loading, shifting nor clearing, that sof_o only appears on a valid bit, that the word counter never passes the number of loaded words, and that done_o holds. Only the bench's scenarios can show the serial content: the right index and count in each word, that empty pixels are skipped in ascending order, the saturation value after thousands of pulses, and that pulses arriving during a readout leave the stream unchanged.

// File: rtl/pxr_pkg.sv
package pxr_pkg;
    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/pxr_cell.sv
module pxr_cell #(
    parameter int CNT_W  = 12,
    parameter int ADDR_W = 7,
    parameter int IDX    = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    input  logic cnt_en_i,
    input  logic clr_i,
    input  logic load_i,
    input  logic shift_i,
    input  logic chain_i,
    output logic chain_o,
    output logic zero_o,
    output logic ovf_o
);
    localparam int WORD_W = ADDR_W + CNT_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [1:0]        sync;
        logic              prev;
        logic [WORD_W-1:0] sr;
        logic              ovf;
        logic              empty;
    } cell_t;

    cell_t q, d;
    logic  rise;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], pulse_i};
        d.prev = q.sync[1];
        rise   = q.sync[1] & ~q.prev;
        if (clr_i) begin
            d.sr  = '0;
            d.ovf = 1'b0;
        end else if (load_i) begin
            d.sr    = {ADDR_W'(IDX), q.sr[CNT_W-1:0]};
            d.empty = (q.sr[CNT_W-1:0] == '0);
        end else if (shift_i) begin
            if (!q.empty) begin
                d.sr = {q.sr[WORD_W-2:0], chain_i};
            end
        end else if (cnt_en_i && rise) begin
            if (q.sr[CNT_W-1:0] == CNT_MAX) begin
                d.ovf = 1'b1;
            end else begin
                d.sr[CNT_W-1:0] = q.sr[CNT_W-1:0] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign chain_o = q.empty ? chain_i : q.sr[WORD_W-1];
    assign zero_o  = (q.sr[CNT_W-1:0] == '0);
    assign ovf_o   = q.ovf;

    // R2: a count moves by at most one per cycle while counting
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_i && !clr_i) |=>
        ((q.sr[CNT_W-1:0] == $past(q.sr[CNT_W-1:0])) ||
         (q.sr[CNT_W-1:0] == $past(q.sr[CNT_W-1:0]) + 1'b1)));

    // R3: a saturated count stays at its limit
    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_i && !clr_i && q.sr[CNT_W-1:0] == CNT_MAX) |=>
        (q.sr[CNT_W-1:0] == CNT_MAX));

    // R3: overflow flag is sticky until a clear
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovf && !clr_i) |=> q.ovf);

    // R5: register is frozen when no operation is selected
    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_i && !clr_i && !load_i && !shift_i) |=> $stable(q.sr));
endmodule

// File: rtl/pxr_ctrl.sv
module pxr_ctrl
    import pxr_pkg::*;
#(
    parameter int NPIX   = 100,
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            readout_i,
    input  logic            clear_i,
    input  logic [NPIX-1:0] zero_i,
    input  logic            chain_i,
    output logic            cnt_en_o,
    output logic            clr_o,
    output logic            load_o,
    output logic            shift_o,
    output logic            sdo_o,
    output logic            valid_o,
    output logic            sof_o,
    output logic            done_o
);
    localparam int WORD_W = ADDR_W + CNT_W;
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int NW_W   = $clog2(NPIX + 1);

    typedef struct packed {
        rd_state_e       st;
        logic [BIT_W-1:0] bitc;
        logic [NW_W-1:0]  word;
        logic [NW_W-1:0]  nwords;
    } ctrl_t;

    ctrl_t q, d;
    logic [NW_W-1:0] nonempty;

    assign nonempty = NW_W'(NPIX) - NW_W'($countones(zero_i));

    always_comb begin
        d = q;
        case (q.st)
            ST_COUNT: begin
                if (readout_i) begin
                    d.nwords = nonempty;
                    d.bitc   = '0;
                    d.word   = '0;
                    d.st     = (nonempty == '0) ? ST_DONE : ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (!readout_i) begin
                    d.st = ST_COUNT;
                end else if (q.bitc == BIT_W'(WORD_W - 1)) begin
                    d.bitc = '0;
                    if (q.word == q.nwords - 1'b1) begin
                        d.st = ST_DONE;
                    end else begin
                        d.word = q.word + 1'b1;
                    end
                end else begin
                    d.bitc = q.bitc + 1'b1;
                end
            end
            ST_DONE: begin
                if (!readout_i) begin
                    d.st = ST_COUNT;
                end
            end
            default: d.st = ST_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_COUNT, bitc: '0, word: '0, nwords: '0};
        end else begin
            q <= d;
        end
    end

    assign cnt_en_o = (q.st == ST_COUNT) && !readout_i;
    assign clr_o    = cnt_en_o && clear_i;
    assign load_o   = (q.st == ST_COUNT) && readout_i;
    assign shift_o  = (q.st == ST_SHIFT) && readout_i;
    assign valid_o  = (q.st == ST_SHIFT);
    assign sdo_o    = valid_o & chain_i;
    assign sof_o    = valid_o && (q.bitc == '0);
    assign done_o   = (q.st == ST_DONE);

    // R6: word start marker only on a valid bit
    p_sof_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> valid_o);

    // R7: word counter never reaches the number of loaded words while shifting
    p_word_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (q.word < q.nwords));

    // R8: completion holds while the read mode is held
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && readout_i) |=> done_o);

    // R8: an all-empty array completes right after entry
    p_empty_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && nonempty == '0) |=> (done_o && !valid_o));

    // R9: leaving read mode returns to counting
    p_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!readout_i && (valid_o || done_o)) |=> (!valid_o && !done_o));
endmodule

// File: rtl/pixel_readout_chain.sv
module pixel_readout_chain #(
    parameter int NPIX  = 100,
    parameter int CNT_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            readout_i,
    input  logic            clear_i,
    input  logic [NPIX-1:0] pulse_i,
    output logic            sdo_o,
    output logic            valid_o,
    output logic            sof_o,
    output logic            done_o,
    output logic [NPIX-1:0] ovf_o
);
    localparam int ADDR_W = $clog2(NPIX);

    logic [NPIX:0]   chain;
    logic [NPIX-1:0] zero;
    logic            cnt_en, clr, load, shift;

    assign chain[NPIX] = 1'b0;

    for (genvar i = 0; i < NPIX; i++) begin : g_pix
        pxr_cell #(
            .CNT_W  (CNT_W),
            .ADDR_W (ADDR_W),
            .IDX    (i)
        ) cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .pulse_i  (pulse_i[i]),
            .cnt_en_i (cnt_en),
            .clr_i    (clr),
            .load_i   (load),
            .shift_i  (shift),
            .chain_i  (chain[i+1]),
            .chain_o  (chain[i]),
            .zero_o   (zero[i]),
            .ovf_o    (ovf_o[i])
        );
    end

    pxr_ctrl #(
        .NPIX   (NPIX),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .readout_i (readout_i),
        .clear_i   (clear_i),
        .zero_i    (zero),
        .chain_i   (chain[0]),
        .cnt_en_o  (cnt_en),
        .clr_o     (clr),
        .load_o    (load),
        .shift_o   (shift),
        .sdo_o     (sdo_o),
        .valid_o   (valid_o),
        .sof_o     (sof_o),
        .done_o    (done_o)
    );
endmodule

// File: tb/pixel_readout_chain_tb_top.sv
`timescale 1ns/1ps
module pixel_readout_chain_tb_top;
    localparam int NPIX  = 100;
    localparam int CMAX  = 4095;
    localparam int WBITS = 19;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            readout_i = 1'b0;
    logic            clear_i = 1'b0;
    logic [NPIX-1:0] pulse_i = '0;
    logic            sdo_o, valid_o, sof_o, done_o;
    logic [NPIX-1:0] ovf_o;

    int checks = 0;
    int errors = 0;
    int exp_cnt [NPIX];
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pixel_readout_chain #(.NPIX(NPIX), .CNT_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .readout_i(readout_i), .clear_i(clear_i),
        .pulse_i(pulse_i), .sdo_o(sdo_o), .valid_o(valid_o), .sof_o(sof_o),
        .done_o(done_o), .ovf_o(ovf_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_mask(input logic [NPIX-1:0] m, input int n, input bit upd);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #3 pulse_i = m;
            repeat (2) @(negedge clk);
            #5 pulse_i = '0;
            repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        if (upd) begin
            for (int i = 0; i < NPIX; i++) begin
                if (m[i]) exp_cnt[i] = (exp_cnt[i] + n > CMAX) ? CMAX : exp_cnt[i] + n;
            end
        end
    endtask

    task automatic clear_frame();
        @(negedge clk); clear_i = 1'b1;
        @(negedge clk); clear_i = 1'b0;
        for (int i = 0; i < NPIX; i++) exp_cnt[i] = 0;
    endtask

    task automatic do_readout(input string req);
        int nexp = 0;
        int got = 0;
        int p = 0;
        int bp = 0;
        int guard = 0;
        logic [WBITS-1:0] w = '0;
        for (int i = 0; i < NPIX; i++) if (exp_cnt[i] != 0) nexp++;
        @(negedge clk); readout_i = 1'b1;
        @(posedge clk);
        while (1) begin
            @(negedge clk);
            guard++;
            if (!valid_o || guard > NPIX * WBITS + 4) break;
            if (bp == 0) chk(sof_o == 1'b1, req, "R6 sof on word start", sof_o, 1);
            else if (sof_o) chk(1'b0, req, "R6 sof inside word", sof_o, 0);
            w = {w[WBITS-2:0], sdo_o};
            bp++;
            if (bp == WBITS) begin
                bp = 0;
                while (p < NPIX && exp_cnt[p] == 0) p++;
                chk(int'(w[18:12]) == p, req, "R7 word index", w[18:12], p);
                chk(p < NPIX && int'(w[11:0]) == exp_cnt[p], req, "R6 word count",
                    w[11:0], (p < NPIX) ? exp_cnt[p] : -1);
                p++;
                got++;
            end
        end
        chk(done_o == 1'b1, req, "R8 done after last bit", done_o, 1);
        chk(got == nexp, req, "R7 number of words", got, nexp);
        chk(bp == 0, req, "R6 whole words only", bp, 0);
        readout_i = 1'b0;
        @(negedge clk);
        chk(!done_o && !valid_o, req, "R9 back to count mode", {done_o, valid_o}, 0);
    endtask

    task automatic t_reset();
        chk(valid_o == 1'b0, "R1", "valid after reset", valid_o, 0);
        chk(done_o == 1'b0 && sof_o == 1'b0, "R1", "done/sof after reset", {done_o, sof_o}, 0);
        chk(ovf_o == '0, "R1", "ovf after reset", ovf_o != '0, 0);
        do_readout("R1 R8 empty array");
        clear_frame();
    endtask

    task automatic t_basic();
        logic [NPIX-1:0] m;
        m = '0; m[0] = 1'b1; m[99] = 1'b1;
        pulse_mask(m, 2, 1'b1);
        m = '0; m[0] = 1'b1;
        pulse_mask(m, 1, 1'b1);
        m = '0; m[7] = 1'b1;
        pulse_mask(m, 1, 1'b1);
        m = '0; m[99] = 1'b1;
        pulse_mask(m, 3, 1'b1);
        do_readout("R2 R6 basic");
        clear_frame();
    endtask

    task automatic t_clear();
        logic [NPIX-1:0] m;
        m = '0; m[10] = 1'b1; m[11] = 1'b1;
        pulse_mask(m, 2, 1'b1);
        clear_frame();
        chk(ovf_o == '0, "R4", "ovf after clear", ovf_o != '0, 0);
        do_readout("R4 cleared frame");
        clear_frame();
    endtask

    task automatic t_sat();
        logic [NPIX-1:0] m;
        m = '0; m[42] = 1'b1;
        pulse_mask(m, 4094, 1'b1);
        chk(ovf_o[42] == 1'b0, "R3", "no ovf below limit", ovf_o[42], 0);
        pulse_mask(m, 3, 1'b1);
        chk(ovf_o[42] == 1'b1, "R3", "ovf set at saturation", ovf_o[42], 1);
        chk($countones(ovf_o) == 1, "R3", "ovf only on pulsed pixel", $countones(ovf_o), 1);
        do_readout("R3 saturated value");
        chk(ovf_o[42] == 1'b1, "R3", "ovf sticky through readout", ovf_o[42], 1);
        clear_frame();
        chk(ovf_o[42] == 1'b0, "R4", "clear drops ovf", ovf_o[42], 0);
    endtask

    task automatic t_ignore();
        logic [NPIX-1:0] m;
        m = '0; m[2] = 1'b1;
        pulse_mask(m, 2, 1'b1);
        m = '0; m[50] = 1'b1;
        pulse_mask(m, 1, 1'b1);
        m = '0; m[2] = 1'b1; m[3] = 1'b1;
        fork
            do_readout("R5 pulses during readout");
            begin
                repeat (3) @(negedge clk);
                pulse_mask(m, 4, 1'b0);
            end
        join
        clear_frame();
    endtask

    task automatic t_many();
        logic [NPIX-1:0] m;
        for (int k = 1; k <= 4; k++) begin
            m = '0;
            for (int i = 0; i < NPIX; i++) if (i % 3 == 1 && (i % 4) + 1 >= k) m[i] = 1'b1;
            pulse_mask(m, 1, 1'b1);
        end
        do_readout("R7 sparse pattern");
        clear_frame();
        m = '0; m[5] = 1'b1;
        pulse_mask(m, 1, 1'b1);
        do_readout("R9 count after return");
        clear_frame();
    endtask

    initial begin
        for (int i = 0; i < NPIX; i++) exp_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_clear();
        t_sat();
        t_ignore();
        t_many();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(64'd20 * 64'd190000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule